// File: doc/BRIEF.md
# Half-Bridge Gate Timer with Dead Time and Driver Delay Compensation

This block turns a single leg command for one half-bridge into two gate enables, one for the high-side switch and one for the low-side switch. When the command changes, the side being released is turned off at once and the newly selected side is held off for a programmable dead time, counted in clock cycles. Each of the four gate edges (high rise, high fall, low rise, low fall) then passes through its own extra cycle delay, so that unequal turn-on and turn-off propagation delays of the external drivers can be cancelled. All counts are constant inputs, whole clock cycles, 8 bits wide.

A final interlock watches the two timed signals. If compensation values are set so badly that both would be on together, both gate enables are forced off and a sticky fault flag is raised; the block stays in that safe state until reset. A command level of 1 selects the high side, 0 the low side.

Top module: `hb_gate_timer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both gate enables and the fault flag are 0.
- R2: After reset the command reference is 0; both gates stay off until the command is first seen at 1, so a command held at 0 from reset never turns on either gate.
- R3: Counting the rising clock edge that first samples a command change as edge 0, the newly selected gate turns on at edge 2 + dead + rise delay of that side.
- R4: The gate being released turns off at edge 1 + fall delay of that side, counted the same way as in R3.
- R5: The four edge delays are independent: the high rise, high fall, low rise and low fall values each move only their own edge.
- R6: A command change arriving while a dead-time count is running restarts the sequence: both requests are dropped and the full dead time is counted again from the later change, so a side deselected before its dead time ends never turns on.
- R7: The high and low gate enables are never 1 in the same cycle.
- R8: If the timed high and low signals would overlap, both gate enables are 0 from the first overlapping cycle, the fault flag rises on the next edge and stays 1, and both gates stay off until reset.
- R9: All counts are 8 bits; a value of 0 adds no cycles beyond the fixed latency of R3 and R4, and values up to 255 are honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 1 | Leg command: 1 selects high side, 0 low side |
| dead_cyc_i | input | 8 | Dead-time count in cycles |
| hi_rise_dly_i | input | 8 | Extra cycles before high gate turn-on |
| hi_fall_dly_i | input | 8 | Extra cycles before high gate turn-off |
| lo_rise_dly_i | input | 8 | Extra cycles before low gate turn-on |
| lo_fall_dly_i | input | 8 | Extra cycles before low gate turn-off |
| hi_gate_o | output | 1 | High-side gate enable |
| lo_gate_o | output | 1 | Low-side gate enable |
| fault_o | output | 1 | Sticky overlap fault |

## Verification
The assertions guard, on every cycle, that the two gate enables never coincide, that an overlap of the timed signals raises the fault and that the fault keeps both gates off, that a command change drops both requests, and that a timed signal only moves towards its request. The exact edge latencies, the independence of the four delays, the restart on a command change inside the dead time and the reset hold-off are only visible through the bench's sweeps, which compute each edge cycle arithmetically from the dead and delay values over every combination of 0 to 3, plus full-range and restart cases.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
  parameter int unsigned DEF_CNT_W = 8;
  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned SIDE_HI   = 0;
  localparam int unsigned SIDE_LO   = 1;
endpackage

// File: rtl/hb_dead_seq.sv
module hb_dead_seq #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_i,
  input  logic [CNT_W-1:0] dead_cyc_i,
  output logic             hi_req_o,
  output logic             lo_req_o
);
  logic             cmd_q;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= 1'b0;
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      hi_req_o <= 1'b0;
      lo_req_o <= 1'b0;
    end else if (cmd_i != cmd_q) begin
      // new edge, or restart mid-count: drop both, count from zero
      cmd_q    <= cmd_i;
      busy_q   <= 1'b1;
      cnt_q    <= '0;
      hi_req_o <= 1'b0;
      lo_req_o <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == dead_cyc_i) begin
        busy_q   <= 1'b0;
        hi_req_o <= cmd_q;
        lo_req_o <= !cmd_q;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R6
  // req_drop_chk
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != $past(cmd_i)) |=> (!hi_req_o && !lo_req_o));

  // R7
  // req_gap_chk
  req_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_req_o) |-> $past(!lo_req_o));
endmodule

// File: rtl/hb_edge_delay.sv
module hb_edge_delay #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CNT_W-1:0] rise_dly_i,
  input  logic [CNT_W-1:0] fall_dly_i,
  output logic             out_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] dly_sel;

  always_comb dly_sel = req_i ? rise_dly_i : fall_dly_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o <= 1'b0;
      cnt_q <= '0;
    end else if (req_i == out_o) begin
      cnt_q <= '0;
    end else if (cnt_q == dly_sel) begin
      out_o <= req_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R4
  // edge_follow_chk
  edge_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_o != $past(out_o)) |-> (out_o == $past(req_i)));
endmodule

// File: rtl/hb_interlock.sv
module hb_interlock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_t_i,
  input  logic lo_t_i,
  output logic hi_gate_o,
  output logic lo_gate_o,
  output logic fault_o
);
  logic overlap;
  logic block;

  always_comb begin
    overlap   = hi_t_i & lo_t_i;
    block     = overlap | fault_o;
    hi_gate_o = hi_t_i & ~block;
    lo_gate_o = lo_t_i & ~block;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_o <= 1'b0;
    else         fault_o <= fault_o | overlap;
  end

  // R7
  // no_overlap_chk
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_gate_o && lo_gate_o));

  // R8
  // fault_set_chk
  fault_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_t_i && lo_t_i) |=> fault_o);

  // R8
  // fault_sticky_chk
  fault_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);

  // R8
  // fault_mask_chk
  fault_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!hi_gate_o && !lo_gate_o));
endmodule

// File: rtl/hb_gate_timer.sv
module hb_gate_timer
  import hb_gate_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_i,
  input  logic [CNT_W-1:0] dead_cyc_i,
  input  logic [CNT_W-1:0] hi_rise_dly_i,
  input  logic [CNT_W-1:0] hi_fall_dly_i,
  input  logic [CNT_W-1:0] lo_rise_dly_i,
  input  logic [CNT_W-1:0] lo_fall_dly_i,
  output logic             hi_gate_o,
  output logic             lo_gate_o,
  output logic             fault_o
);
  logic [NUM_SIDES-1:0]            req;
  logic [NUM_SIDES-1:0]            timed;
  logic [NUM_SIDES-1:0][CNT_W-1:0] rise_d;
  logic [NUM_SIDES-1:0][CNT_W-1:0] fall_d;

  always_comb begin
    rise_d[SIDE_HI] = hi_rise_dly_i;
    fall_d[SIDE_HI] = hi_fall_dly_i;
    rise_d[SIDE_LO] = lo_rise_dly_i;
    fall_d[SIDE_LO] = lo_fall_dly_i;
  end

  hb_dead_seq #(.CNT_W(CNT_W)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd_i),
    .dead_cyc_i (dead_cyc_i),
    .hi_req_o   (req[SIDE_HI]),
    .lo_req_o   (req[SIDE_LO])
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    hb_edge_delay #(.CNT_W(CNT_W)) i_dly (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (req[s]),
      .rise_dly_i (rise_d[s]),
      .fall_dly_i (fall_d[s]),
      .out_o      (timed[s])
    );
  end

  hb_interlock i_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hi_t_i    (timed[SIDE_HI]),
    .lo_t_i    (timed[SIDE_LO]),
    .hi_gate_o (hi_gate_o),
    .lo_gate_o (lo_gate_o),
    .fault_o   (fault_o)
  );

  // R3
  // gate_on_req_chk
  gate_on_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_gate_o) |-> req[SIDE_HI]);

  // R3
  // lo_on_req_chk
  lo_on_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lo_gate_o) |-> req[SIDE_LO]);
endmodule

// File: tb/test_hb_gate_timer.sv
module test_hb_gate_timer;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_i = 1'b0;
  logic [7:0] dead_cyc_i = '0;
  logic [7:0] hi_rise_dly_i = '0, hi_fall_dly_i = '0;
  logic [7:0] lo_rise_dly_i = '0, lo_fall_dly_i = '0;
  logic       hi_gate_o, lo_gate_o, fault_o;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hb_gate_timer i_hb_gate_timer (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .dead_cyc_i(dead_cyc_i),
    .hi_rise_dly_i(hi_rise_dly_i), .hi_fall_dly_i(hi_fall_dly_i),
    .lo_rise_dly_i(lo_rise_dly_i), .lo_fall_dly_i(lo_fall_dly_i),
    .hi_gate_o(hi_gate_o), .lo_gate_o(lo_gate_o), .fault_o(fault_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    cmd_i  = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // drive command, then record first change cycle of each gate relative to edge 0
  task automatic run_phase(input logic c, input int win, output int hi_chg, output int lo_chg);
    logic ph, pl;
    int   te;
    bit   both;
    ph = hi_gate_o; pl = lo_gate_o;
    hi_chg = -1; lo_chg = -1; both = 1'b0;
    cmd_i = c;
    te = cyc + 1;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      if (hi_gate_o != ph && hi_chg < 0) hi_chg = cyc - te;
      if (lo_gate_o != pl && lo_chg < 0) lo_chg = cyc - te;
      if (hi_gate_o && lo_gate_o) both = 1'b1;
    end
    chk(!both, "R7 both gates on", int'(both), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int h, l, exp_h, exp_l;
    bit ov;
    @(negedge clk);
    // exhaustive sweep, counts 0..3
    for (int d = 0; d < 4; d++)
    for (int hr = 0; hr < 4; hr++)
    for (int hf = 0; hf < 4; hf++)
    for (int lr = 0; lr < 4; lr++)
    for (int lf = 0; lf < 4; lf++) begin
      dead_cyc_i = 8'(d);
      hi_rise_dly_i = 8'(hr); hi_fall_dly_i = 8'(hf);
      lo_rise_dly_i = 8'(lr); lo_fall_dly_i = 8'(lf);
      do_reset();
      chk({hi_gate_o, lo_gate_o, fault_o} == 3'b000, "R1 reset state",
          int'({hi_gate_o, lo_gate_o, fault_o}), 0);
      repeat (3) @(negedge clk);
      chk(!hi_gate_o && !lo_gate_o, "R2 hold-off with cmd 0",
          int'({hi_gate_o, lo_gate_o}), 0);
      // first edge: high side on
      run_phase(1'b1, 14, h, l);
      chk(h == 2 + d + hr, "R3 R5 high turn-on", h, 2 + d + hr);
      chk(l == -1, "R2 low stays off", l, -1);
      // low side on, high off
      run_phase(1'b0, 14, h, l);
      ov = (d + lr + 1) < hf;
      if (!ov) begin
        chk(h == 1 + hf, "R4 R5 high turn-off", h, 1 + hf);
        chk(l == 2 + d + lr, "R3 R5 low turn-on", l, 2 + d + lr);
        chk(fault_o == 1'b0, "R8 no fault", int'(fault_o), 0);
        run_phase(1'b1, 14, h, l);
        ov = (d + hr + 1) < lf;
        if (!ov) begin
          chk(l == 1 + lf, "R4 R5 low turn-off", l, 1 + lf);
          chk(h == 2 + d + hr, "R3 R5 high turn-on again", h, 2 + d + hr);
          chk(fault_o == 1'b0, "R8 no fault", int'(fault_o), 0);
        end else begin
          chk(l == 2 + d + hr, "R8 low masked at overlap", l, 2 + d + hr);
          chk(h == -1, "R8 high masked", h, -1);
          chk(fault_o == 1'b1, "R8 fault raised", int'(fault_o), 1);
        end
      end else begin
        chk(h == 2 + d + lr, "R8 high masked at overlap", h, 2 + d + lr);
        chk(l == -1, "R8 low masked", l, -1);
        chk(fault_o == 1'b1, "R8 fault raised", int'(fault_o), 1);
        run_phase(1'b1, 14, h, l);
        chk(h == -1 && l == -1, "R8 gates stay off", h, -1);
        chk(fault_o == 1'b1, "R8 fault sticky", int'(fault_o), 1);
      end
    end

    // all-zero counts: fixed latency only
    dead_cyc_i = '0; hi_rise_dly_i = '0; hi_fall_dly_i = '0;
    lo_rise_dly_i = '0; lo_fall_dly_i = '0;
    do_reset();
    run_phase(1'b1, 6, h, l);
    chk(h == 2, "R9 zero counts turn-on", h, 2);
    run_phase(1'b0, 6, h, l);
    chk(h == 1, "R9 zero counts turn-off", h, 1);
    chk(l == 2, "R9 zero counts low turn-on", l, 2);

    // large counts
    dead_cyc_i = 8'd200; hi_rise_dly_i = 8'd40; hi_fall_dly_i = 8'd255;
    lo_rise_dly_i = 8'd60; lo_fall_dly_i = 8'd0;
    do_reset();
    run_phase(1'b1, 260, h, l);
    chk(h == 242, "R9 large high turn-on", h, 242);
    run_phase(1'b0, 300, h, l);
    exp_h = 256; exp_l = 262;
    chk(h == exp_h, "R9 high fall 255", h, exp_h);
    chk(l == exp_l, "R9 low rise", l, exp_l);
    chk(fault_o == 1'b0, "R8 no fault large", int'(fault_o), 0);

    // restart inside dead time
    dead_cyc_i = 8'd6; hi_rise_dly_i = '0; hi_fall_dly_i = '0;
    lo_rise_dly_i = '0; lo_fall_dly_i = '0;
    do_reset();
    run_phase(1'b1, 3, h, l);
    chk(h == -1, "R6 high not yet on", h, -1);
    run_phase(1'b0, 14, h, l);
    chk(h == -1, "R6 deselected high never on", h, -1);
    chk(l == 8, "R6 low after full dead time", l, 8);
    run_phase(1'b1, 3, h, l);
    chk(l == 1, "R6 low released", l, 1);
    run_phase(1'b0, 14, h, l);
    exp_l = 8;
    chk(h == -1, "R6 high stays off", h, -1);
    chk(l == exp_l, "R6 low back after restart", l, exp_l);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule